// File: doc/BRIEF.md
# PCI Bus-Master Burst Initiator

This block is the initiator half of a 32-bit PCI bus master. A local requester hands it one block move at a time: a start address, a byte count, a direction, whether the memory holds a data buffer or a control structure, an enable for the write-and-invalidate command, and a byte limit for reads. The block sizes the burst, requests the bus, drives one address phase carrying the PCI command, and then runs consecutive data phases. Read data goes into an internal FIFO. Write data comes out of that FIFO.

The burst length is fixed when the request is accepted. It is the smallest of three values: the requested word count, the room (for reads) or the fill (for writes) of the FIFO, and, for reads only, the programmed byte limit. A limit of zero means no limit. If no claiming target answers in time, the burst ends with a master-abort and an error on the completion pulse. The requester reads the completion count to find out how much moved, and issues the remainder as a new request.

Top module: `pci_burst_master`

## Requirements
- R1: While reset is held and after its release, `req_n`, `frame_n` and `irdy_n` are 1; `ad_oe`, `cbe_oe`, `busy` and `done` are 0.
- R2: The address-phase command on `cbe_n` is 4'hC for a data-buffer read, 4'hE for a control-structure read and 4'h7 for a control-structure write. For a data-buffer write it is 4'hF when `mwi_en` is 1 and 4'h7 when it is 0.
- R3: `req_n` is 0 from the cycle after acceptance until `gnt_n` is sampled 0. The next cycle is the only address phase: `frame_n`=0, `irdy_n`=1, `ad_oe`=1, `ad_out` equal to the start address, `cbe_n` equal to the command. The data phases start in the following cycle.
- R4: In every data phase `cbe_n` is 4'b0000, meaning all byte lanes are enabled. `irdy_n` stays 0 on every data cycle until the final handshake, so there are no initiator wait states.
- R5: A word moves only in a cycle where `irdy_n`, `trdy_n` and `devsel_n` are all 0. In a target wait cycle there is no FIFO strobe, and the write data on `ad_out` holds.
- R6: `frame_n` is 1 in exactly the data cycles of the last word and 0 in earlier data cycles. In the cycle after the final handshake, `irdy_n` and `frame_n` are both 1.
- R7: Burst length in words is min(`req_bytes`/4, `fifo_space`, `max_bytes`/4) for reads and min(`req_bytes`/4, `fifo_level`) for writes. `max_bytes` has no effect on writes.
- R8: A read with `max_bytes` = 0 is bounded only by the request and `fifo_space`.
- R9: A request whose burst length is zero produces `done` in the next cycle with `xfer_words`=0, and `req_n` stays 1.
- R10: If `devsel_n` is still 1 in the fifth clock after the address phase, the next cycle has `frame_n`=1 and `irdy_n`=0. The cycle after that has `done`=1, `err`=1 and `xfer_words`=0.
- R11: `done` pulses for one cycle in the cycle after the final handshake, with `err`=0 and `xfer_words` equal to the burst length.
- R12: Each read transfer pulses `fifo_wr_en` with `fifo_wr_data` equal to `ad_in`. Each write transfer pulses `fifo_rd_en`, and in write data phases `ad_out` carries `fifo_rd_data` with `ad_oe`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | BUS_W | Start byte address of the burst |
| req_bytes | input | CNT_W | Requested byte count |
| req_write | input | 1 | 1 = memory write, 0 = memory read |
| req_ctrl | input | 1 | 1 = control structure, 0 = data buffer |
| mwi_en | input | 1 | Allows write-and-invalidate for data-buffer writes |
| max_bytes | input | CNT_W | Read byte limit, 0 = unlimited |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Master-abort, valid with done |
| xfer_words | output | CNT_W | Words moved, valid with done |
| fifo_space | input | LVL_W | Free FIFO words (reads) |
| fifo_level | input | LVL_W | Filled FIFO words (writes) |
| fifo_wr_en | output | 1 | Push read word into FIFO |
| fifo_wr_data | output | BUS_W | Word pushed into FIFO |
| fifo_rd_en | output | 1 | Pop the FIFO head word |
| fifo_rd_data | input | BUS_W | FIFO head word (show-ahead) |
| req_n | output | 1 | Bus request, active low |
| gnt_n | input | 1 | Bus grant, active low |
| frame_n | output | 1 | FRAME#, active low |
| irdy_n | output | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| devsel_n | input | 1 | DEVSEL#, active low |
| ad_in | input | BUS_W | AD bus as received |
| ad_out | output | BUS_W | AD bus value to drive |
| ad_oe | output | 1 | AD output enable |
| cbe_n | output | 4 | Command / byte enables |
| cbe_oe | output | 1 | C/BE# output enable |

## Verification
Every pin is decoded from registered state. A request therefore shows its effect one clock after acceptance: `req_n` falls, or `done` pulses for an empty burst. The address phase comes one clock after the grant is sampled. A handshake moves the word in the same cycle, through the FIFO strobe, and `done` arrives one clock after the last handshake. A master-abort shows one clock after the fifth unanswered data clock, and `done` follows one clock later. The bench drives its target model on the falling edge and samples one nanosecond later, so each check sees the values of the current bus cycle. Words counted by the model are applied at the next falling edge, which keeps the model's beat count aligned with the design's state after that clock edge.

// File: rtl/pci_bm_pkg.sv
`timescale 1ns/1ps
package pci_bm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_DATA,
    ST_ABORT,
    ST_TURN
  } bm_state_e;

  localparam logic [3:0] CMD_RD_MULT  = 4'hC;
  localparam logic [3:0] CMD_RD_LINE  = 4'hE;
  localparam logic [3:0] CMD_WR       = 4'h7;
  localparam logic [3:0] CMD_WR_INVAL = 4'hF;

  // Command selection from direction and structure class
  function automatic logic [3:0] pick_cmd(input logic wr, input logic ctrl,
                                          input logic inval_ok);
    logic [3:0] c;
    if (!wr)       c = ctrl ? CMD_RD_LINE : CMD_RD_MULT;
    else if (ctrl) c = CMD_WR;
    else           c = inval_ok ? CMD_WR_INVAL : CMD_WR;
    return c;
  endfunction

endpackage

// File: rtl/pci_bm_planner.sv
`timescale 1ns/1ps
module pci_bm_planner
  import pci_bm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LVL_W = 5
) (
  input  logic [CNT_W-1:0] req_bytes,
  input  logic [CNT_W-1:0] max_bytes,
  input  logic             req_write,
  input  logic             req_ctrl,
  input  logic             mwi_en,
  input  logic [LVL_W-1:0] fifo_space,
  input  logic [LVL_W-1:0] fifo_level,
  output logic [CNT_W-1:0] burst_words,
  output logic [3:0]       cmd
);

  // Smallest of request, optional cap and FIFO availability, in words
  function automatic logic [CNT_W-1:0] clip_words(input logic [CNT_W-1:0] nbytes,
                                                  input logic [CNT_W-1:0] cap,
                                                  input logic [CNT_W-1:0] avail,
                                                  input logic cap_on);
    logic [CNT_W-1:0] w;
    w = nbytes >> 2;
    if (cap_on && (cap != '0) && ((cap >> 2) < w)) w = cap >> 2;
    if (avail < w) w = avail;
    return w;
  endfunction

  logic [CNT_W-1:0] avail_words;

  always_comb begin
    avail_words = req_write ? CNT_W'(fifo_level) : CNT_W'(fifo_space);
    burst_words = clip_words(req_bytes, max_bytes, avail_words, !req_write);
    cmd         = pick_cmd(req_write, req_ctrl, mwi_en);
  end

endmodule

// File: rtl/pci_bm_devsel_timer.sv
`timescale 1ns/1ps
module pci_bm_devsel_timer #(
  parameter int TIMEOUT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic active,
  input  logic devsel_n,
  output logic abort_now
);

  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT);
  localparam logic [TW-1:0] T_ONE  = TW'(1);

  logic [TW-1:0] since_addr_q;
  logic          claimed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_addr_q <= '0;
      claimed_q    <= 1'b0;
    end else if (start) begin
      since_addr_q <= T_ONE;
      claimed_q    <= 1'b0;
    end else if (active) begin
      if (!devsel_n) claimed_q <= 1'b1;
      if (since_addr_q != T_LAST) since_addr_q <= since_addr_q + T_ONE;
    end
  end

  assign abort_now = active && devsel_n && !claimed_q && (since_addr_q == T_LAST);

  // R10: an abort decision always leaves the data phase on the next clock
  assert_abort_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> !active);

  // R10: a target that has claimed the cycle is never aborted
  assert_no_abort_after_claim_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && claimed_q) |-> !abort_now);

endmodule

// File: rtl/pci_bm_seq.sv
`timescale 1ns/1ps
module pci_bm_seq
  import pci_bm_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BUS_W-1:0] req_addr,
  input  logic             req_write,
  input  logic [CNT_W-1:0] burst_words,
  input  logic [3:0]       cmd,
  input  logic             abort_now,
  output logic             addr_phase,
  output logic             data_phase,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] xfer_words,
  output logic             fifo_wr_en,
  output logic [BUS_W-1:0] fifo_wr_data,
  output logic             fifo_rd_en,
  input  logic [BUS_W-1:0] fifo_rd_data,
  output logic             req_n,
  input  logic             gnt_n,
  output logic             frame_n,
  output logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic [3:0]       cbe_n,
  output logic             cbe_oe
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  bm_state_e        state_q;
  logic [BUS_W-1:0] addr_q;
  logic [CNT_W-1:0] words_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       cmd_q;
  logic             wr_q;
  logic             aborted_q;

  logic xfer;
  logic last_beat;

  assign addr_phase = (state_q == ST_ADDR);
  assign data_phase = (state_q == ST_DATA);
  assign xfer       = data_phase && !trdy_n && !devsel_n;
  assign last_beat  = (cnt_q + ONE) == words_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      words_q   <= '0;
      cnt_q     <= '0;
      cmd_q     <= 4'h0;
      wr_q      <= 1'b0;
      aborted_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          addr_q    <= req_addr;
          wr_q      <= req_write;
          cmd_q     <= cmd;
          words_q   <= burst_words;
          cnt_q     <= '0;
          aborted_q <= 1'b0;
          state_q   <= (burst_words == '0) ? ST_TURN : ST_REQ;
        end
        ST_REQ:   if (!gnt_n) state_q <= ST_ADDR;
        ST_ADDR:  state_q <= ST_DATA;
        ST_DATA: begin
          if (abort_now) begin
            aborted_q <= 1'b1;
            state_q   <= ST_ABORT;
          end else if (xfer) begin
            cnt_q <= cnt_q + ONE;
            if (last_beat) state_q <= ST_TURN;
          end
        end
        ST_ABORT: state_q <= ST_TURN;
        ST_TURN:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // Pin decode from registered state
  always_comb begin
    req_n   = !(state_q == ST_REQ);
    frame_n = !(addr_phase || (data_phase && !last_beat));
    irdy_n  = !(data_phase || state_q == ST_ABORT);
    ad_oe   = addr_phase || (data_phase && wr_q);
    ad_out  = addr_phase ? addr_q : ((data_phase && wr_q) ? fifo_rd_data : '0);
    cbe_oe  = addr_phase || data_phase || (state_q == ST_ABORT);
    cbe_n   = addr_phase ? cmd_q : (cbe_oe ? 4'b0000 : 4'hF);
  end

  assign fifo_wr_en   = xfer && !wr_q;
  assign fifo_wr_data = ad_in;
  assign fifo_rd_en   = xfer && wr_q;
  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_TURN);
  assign err          = done && aborted_q;
  assign xfer_words   = cnt_q;

  // R3: the single address phase is followed by a data phase
  assert_addr_to_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n && irdy_n) |=> !irdy_n);

  // R4: IRDY# is never withdrawn before a handshake or an abort
  assert_irdy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_phase && !xfer && !abort_now) |=> !irdy_n);

  // R6: FRAME# only rises while IRDY# is asserted
  assert_frame_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_n) |-> !irdy_n);

  // R7: the word count never passes the planned burst length
  assert_beat_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= words_q);

  // R9: an empty burst completes without asking for the bus
  assert_zero_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && req_valid && burst_words == '0) |=> (done && req_n));

endmodule

// File: rtl/pci_burst_master.sv
`timescale 1ns/1ps
module pci_burst_master
  import pci_bm_pkg::*;
#(
  parameter int BUS_W      = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 16,
  parameter int DEVSEL_TO  = 5,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [BUS_W-1:0] req_addr,
  input  logic [CNT_W-1:0] req_bytes,
  input  logic             req_write,
  input  logic             req_ctrl,
  input  logic             mwi_en,
  input  logic [CNT_W-1:0] max_bytes,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] xfer_words,
  input  logic [LVL_W-1:0] fifo_space,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             fifo_wr_en,
  output logic [BUS_W-1:0] fifo_wr_data,
  output logic             fifo_rd_en,
  input  logic [BUS_W-1:0] fifo_rd_data,
  output logic             req_n,
  input  logic             gnt_n,
  output logic             frame_n,
  output logic             irdy_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic [BUS_W-1:0] ad_in,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe,
  output logic [3:0]       cbe_n,
  output logic             cbe_oe
);

  logic [CNT_W-1:0] burst_words;
  logic [3:0]       cmd;
  logic             addr_phase;
  logic             data_phase;
  logic             abort_now;

  pci_bm_planner #(.CNT_W(CNT_W), .LVL_W(LVL_W)) planner_i (
    .req_bytes   (req_bytes),
    .max_bytes   (max_bytes),
    .req_write   (req_write),
    .req_ctrl    (req_ctrl),
    .mwi_en      (mwi_en),
    .fifo_space  (fifo_space),
    .fifo_level  (fifo_level),
    .burst_words (burst_words),
    .cmd         (cmd)
  );

  pci_bm_devsel_timer #(.TIMEOUT(DEVSEL_TO)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (addr_phase),
    .active    (data_phase),
    .devsel_n  (devsel_n),
    .abort_now (abort_now)
  );

  pci_bm_seq #(.BUS_W(BUS_W), .CNT_W(CNT_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_write    (req_write),
    .burst_words  (burst_words),
    .cmd          (cmd),
    .abort_now    (abort_now),
    .addr_phase   (addr_phase),
    .data_phase   (data_phase),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .xfer_words   (xfer_words),
    .fifo_wr_en   (fifo_wr_en),
    .fifo_wr_data (fifo_wr_data),
    .fifo_rd_en   (fifo_rd_en),
    .fifo_rd_data (fifo_rd_data),
    .req_n        (req_n),
    .gnt_n        (gnt_n),
    .frame_n      (frame_n),
    .irdy_n       (irdy_n),
    .trdy_n       (trdy_n),
    .devsel_n     (devsel_n),
    .ad_in        (ad_in),
    .ad_out       (ad_out),
    .ad_oe        (ad_oe),
    .cbe_n        (cbe_n),
    .cbe_oe       (cbe_oe)
  );

  // R12: a read never pops the FIFO and a write never pushes it
  assert_fifo_dir_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_wr_en && fifo_rd_en));

endmodule

// File: tb/pci_burst_master_tb.sv
`timescale 1ns/1ps
module pci_burst_master_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_bytes = '0;
  logic        req_write = 1'b0;
  logic        req_ctrl = 1'b0;
  logic        mwi_en = 1'b0;
  logic [15:0] max_bytes = '0;
  logic        busy, done, err;
  logic [15:0] xfer_words;
  logic [4:0]  fifo_space = '0;
  logic [4:0]  fifo_level = '0;
  logic        fifo_wr_en, fifo_rd_en;
  logic [31:0] fifo_wr_data, fifo_rd_data;
  logic        req_n, frame_n, irdy_n, ad_oe, cbe_oe;
  logic        gnt_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1;
  logic [31:0] ad_in = '0, ad_out;
  logic [3:0]  cbe_n;

  always #4 clk = ~clk;

  pci_burst_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_write(req_write), .req_ctrl(req_ctrl),
    .mwi_en(mwi_en), .max_bytes(max_bytes), .busy(busy), .done(done),
    .err(err), .xfer_words(xfer_words), .fifo_space(fifo_space),
    .fifo_level(fifo_level), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .fifo_rd_en(fifo_rd_en),
    .fifo_rd_data(fifo_rd_data), .req_n(req_n), .gnt_n(gnt_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .cbe_n(cbe_n), .cbe_oe(cbe_oe)
  );

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;

  // Reference model state
  bit          tactive = 0;
  bit          done_seen = 0;
  bit          exp_wr = 0;
  bit          exp_abort = 0;
  logic [3:0]  exp_cmd = '0;
  logic [31:0] exp_addr = '0;
  int          exp_n = 0;
  int          beats = 0;
  int          dly = 1;
  int          wmod = 0;
  bit          in_burst = 0;
  int          cyc = 0;
  logic [31:0] tgt_addr = '0;
  int          wr_idx = 0;
  bit          xfer_prev = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] src_word(input int k);
    return 32'h1000_0000 + 32'(k);
  endfunction

  assign fifo_rd_data = src_word(wr_idx);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", rq, act, exp, $time);
    end
  endtask

  // Target, arbiter and per-cycle comparison
  always begin
    @(negedge clk);
    if (xfer_prev) begin
      beats++;
      tgt_addr = tgt_addr + 32'd4;
      if (exp_wr) wr_idx++;
    end
    xfer_prev = 0;
    gnt_n = req_n;
    if (rst_n && !frame_n && irdy_n) begin
      in_burst = 1; cyc = 0; tgt_addr = ad_out;
      devsel_n = 1'b1; trdy_n = 1'b1;
    end else if (in_burst && frame_n && irdy_n) begin
      in_burst = 0; devsel_n = 1'b1; trdy_n = 1'b1;
    end else if (in_burst) begin
      cyc++;
      devsel_n = (cyc >= dly) ? 1'b0 : 1'b1;
      trdy_n = devsel_n || ((wmod > 0) && (cyc % wmod == 0));
    end
    ad_in = mem_word(tgt_addr);
    #1;
    if (rst_n && tactive) begin
      if (!frame_n && irdy_n) begin
        chk(ad_oe && ad_out == exp_addr, "R3", ad_out, exp_addr);
        chk(cbe_n == exp_cmd, "R2", {28'd0, cbe_n}, {28'd0, exp_cmd});
      end
      if (exp_n == 0) chk(req_n == 1'b1, "R9", {31'd0, req_n}, 32'd1);
      if (in_burst && cyc >= 1 && beats < exp_n && !exp_abort)
        chk(irdy_n == 1'b0, "R4", {31'd0, irdy_n}, 32'd0);
      if (!irdy_n && !exp_abort) begin
        chk(cbe_n == 4'b0000, "R4", {28'd0, cbe_n}, 32'd0);
        chk(frame_n == (beats == exp_n - 1), "R6", {31'd0, frame_n},
            {31'd0, beats == exp_n - 1});
        if (exp_wr)
          chk(ad_oe && ad_out == src_word(wr_idx), "R5", ad_out, src_word(wr_idx));
        else
          chk(!ad_oe, "R12", {31'd0, ad_oe}, 32'd0);
      end
      if (!irdy_n && exp_abort)
        chk(frame_n == (cyc > 5), "R10", {31'd0, frame_n}, {31'd0, cyc > 5});
      if (in_burst && !irdy_n && !trdy_n && !devsel_n) begin
        xfer_prev = 1;
        if (exp_wr) chk(fifo_rd_en && !fifo_wr_en, "R12", {31'd0, fifo_rd_en}, 32'd1);
        else chk(fifo_wr_en && fifo_wr_data == ad_in, "R12", fifo_wr_data, ad_in);
      end else begin
        chk(!fifo_wr_en && !fifo_rd_en, "R5", {30'd0, fifo_wr_en, fifo_rd_en}, 32'd0);
      end
      if (done) begin
        chk(xfer_words == 16'(exp_abort ? 0 : exp_n), "R7", {16'd0, xfer_words},
            exp_abort ? 32'd0 : 32'(exp_n));
        chk(err == exp_abort, exp_abort ? "R10" : "R11", {31'd0, err}, {31'd0, exp_abort});
        chk(irdy_n && frame_n, "R6", {30'd0, irdy_n, frame_n}, 32'd3);
        done_seen = 1;
      end
    end
  end

  task automatic run(input logic [31:0] a, input int nb, input bit wr, input bit ctrl,
                     input bit mwi, input int maxb, input int avail, input int d,
                     input int wm);
    int w;
    w = nb / 4;
    if (!wr && maxb != 0 && maxb / 4 < w) w = maxb / 4;
    if (avail < w) w = avail;
    @(negedge clk);
    exp_n = w; exp_wr = wr; exp_abort = (d > 5) && (w > 0); exp_addr = a;
    if (!wr) exp_cmd = ctrl ? 4'hE : 4'hC;
    else exp_cmd = (ctrl || !mwi) ? 4'h7 : 4'hF;
    dly = d; wmod = wm; beats = 0; done_seen = 0; tactive = 1;
    req_addr = a; req_bytes = 16'(nb); req_write = wr; req_ctrl = ctrl;
    mwi_en = mwi; max_bytes = 16'(maxb);
    fifo_space = wr ? 5'd0 : 5'(avail);
    fifo_level = wr ? 5'(avail) : 5'd0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done_seen) @(negedge clk);
    @(negedge clk);
    chk(!busy && req_n && frame_n && irdy_n, "R11", {31'd0, busy}, 32'd0);
    tactive = 0;
    repeat (2) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      nerr++; nchk++;
      $display("FAIL R11 watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_n && frame_n && irdy_n && !ad_oe && !cbe_oe && !busy && !done, "R1",
        {25'd0, req_n, frame_n, irdy_n, ad_oe, cbe_oe, busy, done}, 32'h70);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_n && frame_n && irdy_n && !busy, "R1", {28'd0, req_n, frame_n, irdy_n, busy}, 32'he);
    // R2 R8: data-buffer read, no cap
    run(32'h0000_1000, 32, 0, 0, 0, 0, 16, 1, 0);
    // R7: control read bounded by FIFO room
    run(32'h0000_2000, 64, 0, 1, 0, 0, 5, 2, 0);
    // R7: read bounded by byte cap
    run(32'h0000_3000, 64, 0, 0, 0, 12, 16, 3, 0);
    // R2 R5: control write ignores mwi_en, target waits
    run(32'h0000_4000, 16, 1, 1, 1, 0, 10, 1, 3);
    // R2 R7: data write with invalidate, cap has no effect on writes
    run(32'h0000_5000, 40, 1, 0, 1, 8, 16, 2, 2);
    // R2: data write without invalidate, bounded by FIFO fill
    run(32'h0000_6000, 64, 1, 0, 0, 0, 3, 1, 0);
    // R9: no FIFO room gives an empty burst
    run(32'h0000_7000, 16, 0, 0, 0, 0, 0, 1, 0);
    // R10: no target claims the cycle
    run(32'h0000_8000, 16, 0, 0, 0, 0, 16, 99, 0);
    // R6 R10: single word, claim at the last allowed clock
    run(32'h0000_9000, 4, 0, 1, 0, 0, 16, 5, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule